// File: doc/BRIEF.md
# Reset Boot Source Selector

This block settles, once per reset, where the processor fetches its first instruction. It counts clock edges after reset is released and captures the two boot strap pins and the dual-bank option bit on a fixed edge. Values on those inputs at any other time have no effect. The strap pair picks one of three paths: direct user flash, the on-chip loader in system memory, or embedded SRAM.

When the straps select flash and the active-low dual-bank option is enabled, the block does not boot flash directly. It reads the first word of the second flash bank and then, if needed, the first word of the first bank through a single-outstanding synchronous read port. A bank counts as bootable when its first word, taken as an initial stack pointer, lies within the SRAM window given by base and limit inputs. If neither bank qualifies, the block falls back to the loader. The result is presented as a 2-bit target code together with a one-cycle completion pulse.

Top module: `bootSourceSelect`

## Requirements
- R1: The straps and the option word are captured on the fourth rising clock edge with reset released. Values driven before or after that edge do not change the result. With no memory read needed, bootDone rises in the cycle after the fifth edge.
- R2: With strap0=0 and option bit 19 equal to 1, the target is bank 1 (code 0), strap1 is ignored, and no memory read is issued.
- R3: With strap0=1 the target is system memory (code 2) when strap1=0 and SRAM (code 3) when strap1=1. The option bit is ignored and no memory read is issued.
- R4: With strap0=0 and option bit 19 equal to 0, the first read issued is to the bank 2 base 0x0808_0000.
- R5: A first word w is valid when sramBase <= w < sramLimit. A valid bank 2 word gives target code 1 with no further read.
- R6: An invalid bank 2 word causes a second read at the bank 1 base 0x0800_0000. If that word is valid, the target is code 0.
- R7: If both first words are invalid, the target is system memory (code 2) after exactly two reads.
- R8: rdReq is high for exactly one cycle per read, and no new request is issued while a read awaits rdValid.
- R9: During and after reset bootDone is 0. It is high for exactly one cycle per reset. bootTarget holds its value after that pulse until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strap0 | input | 1 | Boot strap pin 0 (1 = non-flash boot) |
| strap1 | input | 1 | Boot strap pin 1 (SRAM vs loader when strap0=1) |
| optWord | input | 32 | Option word; bit 19 is the active-low dual-bank enable |
| sramBase | input | ADDR_W | Inclusive lower bound of the SRAM window |
| sramLimit | input | ADDR_W | Exclusive upper bound of the SRAM window |
| rdReq | output | 1 | One-cycle memory read request |
| rdAddr | output | ADDR_W | Read address, held while the read is pending |
| rdValid | input | 1 | Read data valid |
| rdData | input | DATA_W | Read data |
| bootTarget | output | 2 | 0 bank 1, 1 bank 2, 2 system memory, 3 SRAM |
| bootDone | output | 1 | One-cycle decision pulse |

## Verification
A miscounted edge counter shows up as a target that follows a strap value driven one cycle early or late, or as a completion pulse off its fixed cycle. Either is visible within five cycles of reset release. A wrong control state shows at the read port first, as a missing, repeated or misordered request address, or as a request issued while one is still pending. It then shows at bootTarget, with a bank chosen against the window comparison, or as a second or stretched completion pulse. The sweep exercises the window edges (base, limit minus one, limit, base minus one, zero) for both banks, so an off-by-one bound error changes the reported target in the same run.

// File: rtl/bootsel_pkg.sv
`timescale 1ns/1ps
package bootsel_pkg;

  typedef enum logic [1:0] {
    TGT_BANK1 = 2'd0,
    TGT_BANK2 = 2'd1,
    TGT_SYS   = 2'd2,
    TGT_SRAM  = 2'd3
  } target_e;

  typedef enum logic [2:0] {
    ST_WAIT    = 3'd0,
    ST_REQ_B2  = 3'd1,
    ST_WAIT_B2 = 3'd2,
    ST_REQ_B1  = 3'd3,
    ST_WAIT_B1 = 3'd4,
    ST_DONE    = 3'd5
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    rdReq;
    logic    selBank2;
    logic    loadTarget;
    target_e code;
  } strobes_t;

endpackage

// File: rtl/bootselDatapath.sv
`timescale 1ns/1ps
module bootselDatapath
  import bootsel_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          OPT_W      = 32,
  parameter int          OPT_BIT    = 19,
  parameter int          LATCH_EDGE = 4,
  parameter logic [31:0] BANK1_BASE = 32'h0800_0000,
  parameter logic [31:0] BANK2_BASE = 32'h0808_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strap0,
  input  logic              strap1,
  input  logic [OPT_W-1:0]  optWord,
  input  logic [ADDR_W-1:0] sramBase,
  input  logic [ADDR_W-1:0] sramLimit,
  input  logic [DATA_W-1:0] rdData,
  input  strobes_t          strobes,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              captured,
  output logic              bootB0,
  output logic              bootB1,
  output logic              dualOff,
  output logic              inSram,
  output target_e           target
);

  localparam int CNT_W = $clog2(LATCH_EDGE + 1);
  localparam logic [CNT_W-1:0] CAPTURE_AT = CNT_W'(LATCH_EDGE - 1);
  localparam logic [CNT_W-1:0] CAPTURED_V = CNT_W'(LATCH_EDGE);
  localparam int CMP_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;

  logic [CNT_W-1:0] edgeCnt;
  logic             captureNow;

  assign captureNow = (edgeCnt == CAPTURE_AT);
  assign captured   = (edgeCnt == CAPTURED_V);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (edgeCnt != CAPTURED_V) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootB0  <= 1'b0;
      bootB1  <= 1'b0;
      dualOff <= 1'b1;
    end else if (captureNow) begin
      bootB0  <= strap0;
      bootB1  <= strap1;
      dualOff <= optWord[OPT_BIT];
    end
  end

  assign rdAddr = strobes.selBank2 ? ADDR_W'(BANK2_BASE) : ADDR_W'(BANK1_BASE);

  // window test: inclusive base, exclusive limit
  logic [CMP_W-1:0] wordExt, baseExt, limitExt;
  assign wordExt  = CMP_W'(rdData);
  assign baseExt  = CMP_W'(sramBase);
  assign limitExt = CMP_W'(sramLimit);
  assign inSram   = (wordExt >= baseExt) && (wordExt < limitExt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      target <= TGT_BANK1;
    end else if (strobes.loadTarget) begin
      target <= strobes.code;
    end
  end

endmodule

// File: rtl/bootselCtrl.sv
`timescale 1ns/1ps
module bootselCtrl
  import bootsel_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     captured,
  input  logic     bootB0,
  input  logic     bootB1,
  input  logic     dualOff,
  input  logic     rdValid,
  input  logic     inSram,
  output strobes_t strobes,
  output logic     done
);

  state_e state, nxt;

  always_comb begin
    nxt     = state;
    strobes = '0;
    unique case (state)
      ST_WAIT: begin
        if (captured) begin
          if (bootB0) begin
            strobes.loadTarget = 1'b1;
            strobes.code       = bootB1 ? TGT_SRAM : TGT_SYS;
            nxt                = ST_DONE;
          end else if (dualOff) begin
            strobes.loadTarget = 1'b1;
            strobes.code       = TGT_BANK1;
            nxt                = ST_DONE;
          end else begin
            nxt = ST_REQ_B2;
          end
        end
      end
      ST_REQ_B2: begin
        strobes.rdReq    = 1'b1;
        strobes.selBank2 = 1'b1;
        nxt              = ST_WAIT_B2;
      end
      ST_WAIT_B2: begin
        strobes.selBank2 = 1'b1;
        if (rdValid) begin
          if (inSram) begin
            strobes.loadTarget = 1'b1;
            strobes.code       = TGT_BANK2;
            nxt                = ST_DONE;
          end else begin
            nxt = ST_REQ_B1;
          end
        end
      end
      ST_REQ_B1: begin
        strobes.rdReq = 1'b1;
        nxt           = ST_WAIT_B1;
      end
      ST_WAIT_B1: begin
        if (rdValid) begin
          strobes.loadTarget = 1'b1;
          strobes.code       = inSram ? TGT_BANK1 : TGT_SYS;
          nxt                = ST_DONE;
        end
      end
      ST_DONE: nxt = ST_DONE;
      default: nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_WAIT;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= strobes.loadTarget;
    end
  end

endmodule

// File: rtl/bootSourceSelect.sv
`timescale 1ns/1ps
module bootSourceSelect
  import bootsel_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          OPT_W      = 32,
  parameter int          OPT_BIT    = 19,
  parameter int          LATCH_EDGE = 4,
  parameter logic [31:0] BANK1_BASE = 32'h0800_0000,
  parameter logic [31:0] BANK2_BASE = 32'h0808_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strap0,
  input  logic              strap1,
  input  logic [OPT_W-1:0]  optWord,
  input  logic [ADDR_W-1:0] sramBase,
  input  logic [ADDR_W-1:0] sramLimit,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  output logic [1:0]        bootTarget,
  output logic              bootDone
);

  strobes_t strobes;
  logic     captured, bootB0, bootB1, dualOff, inSram;
  target_e  target;

  bootselDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPT_W(OPT_W), .OPT_BIT(OPT_BIT),
    .LATCH_EDGE(LATCH_EDGE), .BANK1_BASE(BANK1_BASE), .BANK2_BASE(BANK2_BASE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strap0(strap0), .strap1(strap1),
    .optWord(optWord), .sramBase(sramBase), .sramLimit(sramLimit),
    .rdData(rdData), .strobes(strobes), .rdAddr(rdAddr),
    .captured(captured), .bootB0(bootB0), .bootB1(bootB1),
    .dualOff(dualOff), .inSram(inSram), .target(target)
  );

  bootselCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .captured(captured), .bootB0(bootB0),
    .bootB1(bootB1), .dualOff(dualOff), .rdValid(rdValid),
    .inSram(inSram), .strobes(strobes), .done(bootDone)
  );

  assign rdReq      = strobes.rdReq;
  assign bootTarget = target;

endmodule

// File: rtl/bootselChecker.sv
`timescale 1ns/1ps
module bootselChecker #(
  parameter int          ADDR_W     = 32,
  parameter int          LATCH_EDGE = 4,
  parameter logic [31:0] BANK1_BASE = 32'h0800_0000,
  parameter logic [31:0] BANK2_BASE = 32'h0808_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdValid,
  input logic [1:0]        bootTarget,
  input logic              bootDone
);

  localparam int EW = $clog2(LATCH_EDGE + 2);
  localparam logic [EW-1:0] EDGE_SAT = EW'(LATCH_EDGE + 1);

  logic [EW-1:0] edgeCnt;
  logic [1:0]    readCnt;
  logic          pending, doneSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt  <= '0;
      readCnt  <= '0;
      pending  <= 1'b0;
      doneSeen <= 1'b0;
    end else begin
      if (edgeCnt != EDGE_SAT) edgeCnt <= edgeCnt + 1'b1;
      if (rdReq && readCnt != 2'd3) readCnt <= readCnt + 1'b1;
      if (rdReq) pending <= 1'b1;
      else if (rdValid) pending <= 1'b0;
      if (bootDone) doneSeen <= 1'b1;
    end
  end

  assert_no_early_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt <= EW'(LATCH_EDGE)) |-> !bootDone);

  assert_no_early_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt <= EW'(LATCH_EDGE)) |-> !rdReq);

  assert_first_read_bank2_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && readCnt == 2'd0) |-> (rdAddr == ADDR_W'(BANK2_BASE)));

  assert_bank2_single_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (bootDone && bootTarget == 2'd1) |-> (readCnt == 2'd1));

  assert_second_read_bank1_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && readCnt == 2'd1) |-> (rdAddr == ADDR_W'(BANK1_BASE)));

  assert_at_most_two_reads_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (readCnt != 2'd2));

  assert_req_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  assert_no_req_while_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !rdReq);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> !bootDone);

  assert_single_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneSeen |-> !bootDone);

  assert_target_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneSeen |=> $stable(bootTarget));

endmodule

bind bootSourceSelect bootselChecker #(
  .ADDR_W(ADDR_W), .LATCH_EDGE(LATCH_EDGE),
  .BANK1_BASE(BANK1_BASE), .BANK2_BASE(BANK2_BASE)
) i_chk (
  .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAddr(rdAddr),
  .rdValid(rdValid), .bootTarget(bootTarget), .bootDone(bootDone)
);

// File: tb/test_bootSourceSelect.sv
`timescale 1ns/1ps
module test_bootSourceSelect;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] B1 = 32'h0800_0000;
  localparam logic [31:0] B2 = 32'h0808_0000;
  localparam logic [31:0] SBASE = 32'h2000_0000;
  localparam logic [31:0] SLIM  = 32'h2000_5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strap0 = 1'b0, strap1 = 1'b0;
  logic [31:0] optWord = 32'hFFFF_FFFF;
  logic [31:0] sramBase = SBASE, sramLimit = SLIM;
  logic        rdReq;
  logic [31:0] rdAddr;
  logic        rdValid = 1'b0;
  logic [31:0] rdData = 32'hDEAD_BEEF;
  logic [1:0]  bootTarget;
  logic        bootDone;

  int total = 0, bad = 0;

  // memory model state
  logic [31:0] memW1, memW2;
  int          memLat = 1;
  int          reads = 0;
  logic [31:0] addrLog [4];
  int          pendCnt = 0;
  bit          pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bootSourceSelect i_bootSourceSelect (
    .clk(clk), .rstN(rstN), .strap0(strap0), .strap1(strap1),
    .optWord(optWord), .sramBase(sramBase), .sramLimit(sramLimit),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
    .bootTarget(bootTarget), .bootDone(bootDone)
  );

  logic [31:0] lastAddr;
  always @(negedge clk) begin
    if (!rstN) begin
      reads   = 0;
      pend    = 0;
      rdValid = 1'b0;
      rdData  = 32'hDEAD_BEEF;
    end else begin
      rdValid = 1'b0;
      rdData  = 32'hDEAD_BEEF;
      if (pend) begin
        pendCnt = pendCnt - 1;
        if (pendCnt == 0) begin
          rdValid = 1'b1;
          rdData  = (lastAddr == B2) ? memW2 : memW1;
          pend    = 0;
        end
      end
      if (rdReq) begin
        if (reads < 4) addrLog[reads] = rdAddr;
        reads    = reads + 1;
        lastAddr = rdAddr;
        pend     = 1;
        pendCnt  = memLat;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit inWin(input logic [31:0] w);
    return (w >= SBASE) && (w < SLIM);
  endfunction

  task automatic runCase(input bit b0, input bit b1, input bit optBit,
                         input logic [31:0] w2, input logic [31:0] w1, input int lat);
    logic [1:0] expT;
    int         expReads;
    string      tReq;
    int         doneCnt, firstAt;
    logic [1:0] tgt;
    bit         unstable;
    if (b0) begin
      expT = b1 ? 2'd3 : 2'd2; expReads = 0; tReq = "R3";
    end else if (optBit) begin
      expT = 2'd0; expReads = 0; tReq = "R2";
    end else if (inWin(w2)) begin
      expT = 2'd1; expReads = 1; tReq = "R5";
    end else if (inWin(w1)) begin
      expT = 2'd0; expReads = 2; tReq = "R6";
    end else begin
      expT = 2'd2; expReads = 2; tReq = "R7";
    end
    memW1 = w1; memW2 = w2; memLat = lat;
    @(negedge clk);
    rstN = 1'b0;
    strap0 = ~b0; strap1 = ~b1;
    optWord = 32'h5A5A_A5A5;
    optWord[19] = ~optBit;
    repeat (3) @(negedge clk);
    check(bootDone == 1'b0, "R9 reset done", 32'(bootDone), 0);
    check(rdReq == 1'b0, "R8 reset req", 32'(rdReq), 0);
    rstN = 1'b1;
    repeat (3) @(posedge clk);            // edges 1..3 see inverted values
    @(negedge clk);
    strap0 = b0; strap1 = b1;
    optWord[19] = optBit;
    @(posedge clk);                       // edge 4 captures
    @(negedge clk);
    strap0 = ~b0; strap1 = ~b1;          // R1: later values ignored
    optWord[19] = ~optBit;
    doneCnt = 0; firstAt = 0; tgt = 2'd0; unstable = 0;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (doneCnt > 0 && bootTarget != tgt) unstable = 1;
      if (bootDone) begin
        doneCnt++;
        if (doneCnt == 1) begin
          firstAt = k; tgt = bootTarget;
        end
      end
    end
    check(doneCnt == 1, "R9 done pulse count", 32'(doneCnt), 1);
    check(tgt == expT, tReq, 32'(tgt), 32'(expT));
    check(!unstable, "R9 target stable", 32'(unstable), 0);
    check(reads == expReads, {tReq, " read count"}, 32'(reads), 32'(expReads));
    if (expReads == 0)
      check(firstAt == 1, "R1 done cycle", 32'(firstAt), 1);
    if (expReads >= 1)
      check(addrLog[0] == B2, "R4 first address", addrLog[0], B2);
    if (expReads == 2)
      check(addrLog[1] == B1, "R6 second address", addrLog[1], B1);
  endtask

  initial begin
    logic [31:0] pats [5];
    pats[0] = SBASE;
    pats[1] = SLIM - 1;
    pats[2] = SLIM;
    pats[3] = SBASE - 1;
    pats[4] = 32'h0;
    // R3: non-flash straps, both option states
    for (int b1 = 0; b1 < 2; b1++)
      for (int ob = 0; ob < 2; ob++)
        runCase(1'b1, b1[0], ob[0], SBASE, SBASE, 1);
    // R2: flash with dual-bank disabled; strap1 varied
    for (int b1 = 0; b1 < 2; b1++)
      runCase(1'b0, b1[0], 1'b1, SBASE, SBASE, 1);
    // R4..R7: dual-bank sweep over window boundary words
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        runCase(1'b0, 1'((i + j) % 2), 1'b0, pats[i], pats[j], 1 + ((i * 5 + j) % 3));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule